// File: doc/BRIEF.md
# Register-Variable Shift Execute Unit

This unit decodes a 32-bit instruction word of the two-source variable-shift family and executes it on two register operands supplied from outside. When the word carries the fixed opcode pattern, the unit shifts the first operand by the second operand's value, taken modulo the active data width. The shift is one of four kinds: logical left, logical right, arithmetic right or rotate right. It delivers the result together with the destination register index and a write-enable one clock later.

A single flag in the word picks 32-bit or 64-bit operation. In 32-bit operation only the low half of the first operand takes part, and the upper half of the result is zero. The source register indices are decoded combinationally so that a surrounding pipeline can fetch the operands. The result path is purely combinational ahead of one output register, so the latency is fixed and independent of the data.

Top module: `vshift_exec`

## Requirements
- R1: Instruction bit 31 selects the data width: 0 gives 32-bit operation and 1 gives 64-bit operation.
- R2: The word is accepted only when bits 30:21 equal 0011010110 and bits 15:12 equal 0010. Otherwise, on the next clock, valid_o and wen_o are low and dst_o and result_o are zero.
- R3: On an accepted word, dst_o equals instruction bits 4:0. src_n_o shows bits 9:5 and src_m_o shows bits 20:16, both combinationally.
- R4: The shift amount is opb_i modulo the data width: only opb_i[4:0] counts in 32-bit mode and only opb_i[5:0] in 64-bit mode, and all higher bits of opb_i have no effect.
- R5: Shift-kind field bits 11:10 = 01 selects logical right shift of opa_i, with zeros filling the vacated high positions.
- R6: Shift-kind field value 00 selects logical left shift, with zeros filling the vacated low positions.
- R7: Shift-kind field value 10 selects arithmetic right shift, filling with the sign bit of the active width (bit 31 in 32-bit mode, bit 63 in 64-bit mode).
- R8: Shift-kind field value 11 selects rotate right, with the bits wrapping within the active width.
- R9: In 32-bit mode only opa_i[31:0] takes part, and result_o[63:32] is zero.
- R10: A reduced shift amount of zero returns opa_i unchanged, truncated to the active width.
- R11: Outputs reflect the inputs present at the preceding rising clock edge, one cycle of latency for every word and operand value, and they do not change between edges.
- R12: A synchronous active-high reset clears valid_o, wen_o, dst_o and result_o at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | 32 | Instruction word |
| opa_i | input | 64 | Value to be shifted |
| opb_i | input | 64 | Shift amount operand |
| src_n_o | output | 5 | Index of the shifted-value register (combinational) |
| src_m_o | output | 5 | Index of the shift-amount register (combinational) |
| valid_o | output | 1 | Registered: the previous word matched the opcode pattern |
| wen_o | output | 1 | Registered write-enable for the destination |
| dst_o | output | 5 | Registered destination register index |
| result_o | output | 64 | Registered shift result |

## Verification
Each output is registered once, so a decode or datapath fault appears at the ports on the first clock after the offending word. A broken stage of the shifter network shows up as wrong bits only for amounts with that stage's bit set. The mix of operand patterns therefore includes amounts with each amount bit set alone and with several set at once. Width-mode faults show as non-zero upper result bits in 32-bit mode, or as a fill or wrap at bit 31 where bit 63 is expected. Opcode-match faults show as valid_o rising on a single-bit corruption of the fixed fields.

// File: rtl/vshift_pkg.sv
package vshift_pkg;

   // shift kind field, instruction bits 11:10
   typedef enum logic [1:0] {
      SK_LSL = 2'b00,
      SK_LSR = 2'b01,
      SK_ASR = 2'b10,
      SK_ROR = 2'b11
   } shift_kind_e;

   // how the right-shift network treats vacated positions
   typedef enum logic [1:0] {
      RF_ZERO = 2'b00,
      RF_SIGN = 2'b01,
      RF_WRAP = 2'b10
   } rfill_e;

   localparam logic [9:0] OPC_HI  = 10'b0011010110;
   localparam logic [3:0] OPC_MID = 4'b0010;

   typedef struct packed {
      logic        match;
      logic        wide;
      shift_kind_e kind;
      logic [4:0]  rd;
      logic [4:0]  rn;
      logic [4:0]  rm;
   } vs_dec_t;

endpackage

// File: rtl/vshift_decode.sv
module vshift_decode
   import vshift_pkg::*;
#(
   parameter int INSTR_W = 32
) (
   input  logic [INSTR_W-1:0] instr_i,
   output vs_dec_t            dec_o
);

   generate
      if (INSTR_W != 32) begin : g_bad_w
         $error("vshift_decode: INSTR_W must be 32");
      end
   endgenerate

   logic hi_ok;
   logic mid_ok;

   assign hi_ok  = (instr_i[30:21] == OPC_HI);
   assign mid_ok = (instr_i[15:12] == OPC_MID);

   always_comb begin
      dec_o.match = hi_ok & mid_ok;
      dec_o.wide  = instr_i[31];
      dec_o.kind  = shift_kind_e'(instr_i[11:10]);
      dec_o.rd    = instr_i[4:0];
      dec_o.rn    = instr_i[9:5];
      dec_o.rm    = instr_i[20:16];
   end

endmodule

// File: rtl/vshift_rshift.sv
module vshift_rshift
   import vshift_pkg::*;
#(
   parameter int W       = 64,
   parameter bit STAGED  = 1'b1,
   localparam int AMT_W  = $clog2(W)
) (
   input  logic [W-1:0]     din_i,
   input  logic [AMT_W-1:0] amt_i,
   input  rfill_e           mode_i,
   output logic [W-1:0]     dout_o
);

   generate
      if ((W & (W - 1)) != 0 || W < 8) begin : g_bad_w
         $error("vshift_rshift: W must be a power of two of at least 8");
      end

      if (STAGED) begin : g_stages
         // log2(W) mux levels, level s moves by 2**s
         logic         fill;
         logic [W-1:0] lvl [AMT_W+1];

         assign fill   = (mode_i == RF_SIGN) & din_i[W-1];
         assign lvl[0] = din_i;

         for (genvar s = 0; s < AMT_W; s++) begin : g_lvl
            localparam int SH = 1 << s;
            logic [W-1:0] moved;
            always_comb begin
               if (mode_i == RF_WRAP)
                  moved = {lvl[s][SH-1:0], lvl[s][W-1:SH]};
               else
                  moved = {{SH{fill}}, lvl[s][W-1:SH]};
            end
            assign lvl[s+1] = amt_i[s] ? moved : lvl[s];
         end

         assign dout_o = lvl[AMT_W];
      end else begin : g_ops
         localparam logic [AMT_W:0] W_L = W;
         logic [AMT_W:0] back;
         assign back = W_L - {1'b0, amt_i};
         always_comb begin
            case (mode_i)
               RF_SIGN: dout_o = W'($signed(din_i) >>> amt_i);
               RF_WRAP: dout_o = (din_i >> amt_i) | (din_i << back);
               default: dout_o = din_i >> amt_i;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/vshift_datapath.sv
module vshift_datapath
   import vshift_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter bit STAGED   = 1'b1,
   localparam int HALF    = XLEN / 2,
   localparam int AMT_W   = $clog2(XLEN),
   localparam int HAMT_W  = $clog2(HALF)
) (
   input  logic            wide_i,
   input  shift_kind_e     kind_i,
   input  logic [XLEN-1:0] opa_i,
   input  logic [XLEN-1:0] opb_i,
   output logic [XLEN-1:0] res_o
);

   function automatic logic [XLEN-1:0] flip(input logic [XLEN-1:0] v);
      logic [XLEN-1:0] r;
      for (int i = 0; i < XLEN; i++) r[i] = v[XLEN-1-i];
      return r;
   endfunction

   logic [AMT_W-1:0] amt;
   logic [HALF-1:0]  lo;
   logic [XLEN-1:0]  norm;
   logic [XLEN-1:0]  pre;
   logic [XLEN-1:0]  rs;
   logic [XLEN-1:0]  post;
   rfill_e           mode;
   logic             unused_hi;

   // modulo by a power-of-two width is a bit select
   assign amt = wide_i ? opb_i[AMT_W-1:0]
                       : {1'b0, opb_i[HAMT_W-1:0]};
   assign unused_hi = ^opb_i[XLEN-1:AMT_W];

   assign lo = opa_i[HALF-1:0];

   // narrow mode is widened so the full-width network gives the
   // narrow answer in the low half
   always_comb begin
      if (wide_i) begin
         norm = opa_i;
      end else begin
         case (kind_i)
            SK_ROR:  norm = {lo, lo};
            SK_ASR:  norm = {{HALF{lo[HALF-1]}}, lo};
            default: norm = {{HALF{1'b0}}, lo};
         endcase
      end
   end

   always_comb begin
      case (kind_i)
         SK_ASR:  mode = RF_SIGN;
         SK_ROR:  mode = RF_WRAP;
         default: mode = RF_ZERO;
      endcase
   end

   // left shift is a right shift of the bit-reversed value
   assign pre = (kind_i == SK_LSL) ? flip(norm) : norm;

   vshift_rshift #(
      .W      (XLEN),
      .STAGED (STAGED)
   ) rsh_i (
      .din_i  (pre),
      .amt_i  (amt),
      .mode_i (mode),
      .dout_o (rs)
   );

   assign post  = (kind_i == SK_LSL) ? flip(rs) : rs;
   assign res_o = wide_i ? post : {{HALF{1'b0}}, post[HALF-1:0]};

endmodule

// File: rtl/vshift_exec.sv
module vshift_exec
   import vshift_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int INSTR_W = 32,
   parameter bit STAGED  = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [INSTR_W-1:0] instr_i,
   input  logic [XLEN-1:0]    opa_i,
   input  logic [XLEN-1:0]    opb_i,
   output logic [4:0]         src_n_o,
   output logic [4:0]         src_m_o,
   output logic               valid_o,
   output logic               wen_o,
   output logic [4:0]         dst_o,
   output logic [XLEN-1:0]    result_o
);

   generate
      if (XLEN != 64) begin : g_bad_xlen
         $error("vshift_exec: XLEN must be 64 (two 32-bit halves)");
      end
   endgenerate

   vs_dec_t         dec;
   logic [XLEN-1:0] dp_res;

   vshift_decode #(
      .INSTR_W (INSTR_W)
   ) dec_i (
      .instr_i (instr_i),
      .dec_o   (dec)
   );

   vshift_datapath #(
      .XLEN   (XLEN),
      .STAGED (STAGED)
   ) dp_i (
      .wide_i (dec.wide),
      .kind_i (dec.kind),
      .opa_i  (opa_i),
      .opb_i  (opb_i),
      .res_o  (dp_res)
   );

   assign src_n_o = dec.rn;
   assign src_m_o = dec.rm;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_o  <= 1'b0;
         wen_o    <= 1'b0;
         dst_o    <= '0;
         result_o <= '0;
      end else begin
         valid_o  <= dec.match;
         wen_o    <= dec.match;
         dst_o    <= dec.match ? dec.rd : 5'd0;
         result_o <= dec.match ? dp_res : '0;
      end
   end

endmodule

// File: rtl/vshift_exec_chk.sv
module vshift_exec_chk #(
   parameter int XLEN    = 64,
   parameter int INSTR_W = 32,
   localparam int HALF   = XLEN / 2,
   localparam int AMT_W  = $clog2(XLEN)
) (
   input logic               clk,
   input logic               rst,
   input logic [INSTR_W-1:0] instr_i,
   input logic [XLEN-1:0]    opa_i,
   input logic [XLEN-1:0]    opb_i,
   input logic               valid_o,
   input logic               wen_o,
   input logic [4:0]         dst_o,
   input logic [XLEN-1:0]    result_o
);

   // set once a clock edge has passed with reset low
   logic arm_q;
   logic unused_chk;

   always_ff @(posedge clk) arm_q <= !rst;

   assign unused_chk = ^{instr_i[20:16], instr_i[9:5], opb_i[XLEN-1:AMT_W]};

   assert_reset_clears_R12: assert property (@(posedge clk)
      rst |=> (!valid_o && !wen_o && dst_o == 5'd0 && result_o == '0));

   assert_match_latency_R11: assert property (@(posedge clk) disable iff (rst)
      arm_q |-> valid_o == $past(instr_i[30:21] == 10'b0011010110 &&
                                 instr_i[15:12] == 4'b0010));

   assert_wen_follows_valid_R2: assert property (@(posedge clk) disable iff (rst)
      wen_o == valid_o);

   assert_reject_zero_R2: assert property (@(posedge clk) disable iff (rst)
      !valid_o |-> (dst_o == 5'd0 && result_o == '0));

   assert_dst_index_R3: assert property (@(posedge clk) disable iff (rst)
      (arm_q && valid_o) |-> dst_o == $past(instr_i[4:0]));

   assert_narrow_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
      (arm_q && valid_o && !$past(instr_i[31])) |-> result_o[XLEN-1:HALF] == '0);

   assert_zero_amount_R10: assert property (@(posedge clk) disable iff (rst)
      (arm_q && valid_o && $past(instr_i[31]) && $past(opb_i[AMT_W-1:0]) == '0)
      |-> result_o == $past(opa_i));

   assert_lsr_top_clear_R5: assert property (@(posedge clk) disable iff (rst)
      (arm_q && valid_o && $past(instr_i[31]) && $past(instr_i[11:10]) == 2'b01 &&
       $past(opb_i[AMT_W-1:0]) != '0) |-> !result_o[XLEN-1]);

endmodule

bind vshift_exec vshift_exec_chk #(
   .XLEN    (XLEN),
   .INSTR_W (INSTR_W)
) chk_i (
   .clk      (clk),
   .rst      (rst),
   .instr_i  (instr_i),
   .opa_i    (opa_i),
   .opb_i    (opb_i),
   .valid_o  (valid_o),
   .wen_o    (wen_o),
   .dst_o    (dst_o),
   .result_o (result_o)
);

// File: tb/vshift_exec_tb.sv
module vshift_exec_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr_i = '0;
   logic [63:0] opa_i = '0;
   logic [63:0] opb_i = '0;
   logic [4:0]  src_n_o, src_m_o, dst_o;
   logic        valid_o, wen_o;
   logic [63:0] result_o;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vshift_exec dut_i (
      .clk      (clk),
      .rst      (rst),
      .instr_i  (instr_i),
      .opa_i    (opa_i),
      .opb_i    (opb_i),
      .src_n_o  (src_n_o),
      .src_m_o  (src_m_o),
      .valid_o  (valid_o),
      .wen_o    (wen_o),
      .dst_o    (dst_o),
      .result_o (result_o)
   );

   // expected outputs of the most recent accepted stimulus
   logic        e_valid;
   logic [4:0]  e_dst;
   logic [63:0] e_res;

   function automatic logic [31:0] mk(bit sf, logic [4:0] rm, logic [1:0] kind,
                                      logic [4:0] rn, logic [4:0] rd);
      return {sf, 10'b0011010110, rm, 4'b0010, kind, rn, rd};
   endfunction

   // behavioural reference, bit by bit
   task automatic model(input logic [31:0] ins, input logic [63:0] a,
                        input logic [63:0] b);
      int width, amt, src;
      logic [63:0] r;
      e_valid = (ins[30:21] == 10'h0D6) && (ins[15:12] == 4'h2);
      width = ins[31] ? 64 : 32;
      amt = int'(b % 64'(width));
      r = '0;
      for (int i = 0; i < width; i++) begin
         case (ins[11:10])
            2'b00: r[i] = (i - amt >= 0) ? a[i-amt] : 1'b0;
            2'b01: r[i] = (i + amt < width) ? a[i+amt] : 1'b0;
            2'b10: r[i] = (i + amt < width) ? a[i+amt] : a[width-1];
            default: begin
               src = (i + amt) % width;
               r[i] = a[src];
            end
         endcase
      end
      e_dst = e_valid ? ins[4:0] : 5'd0;
      e_res = e_valid ? r : 64'd0;
   endtask

   task automatic check(input string tag);
      n_checks++;
      if (valid_o !== e_valid || wen_o !== e_valid || dst_o !== e_dst ||
          result_o !== e_res) begin
         n_fail++;
         $display("FAIL %s: got v=%0b w=%0b d=%0d r=%h exp v=%0b w=%0b d=%0d r=%h",
                  tag, valid_o, wen_o, dst_o, result_o,
                  e_valid, e_valid, e_dst, e_res);
      end
   endtask

   // drive at the falling edge, compare a quarter period after the rising edge
   task automatic run(input logic [31:0] ins, input logic [63:0] a,
                      input logic [63:0] b, input string tag);
      @(negedge clk);
      instr_i = ins; opa_i = a; opb_i = b;
      @(posedge clk);
      model(ins, a, b);
      #(CLK_PERIOD/4);
      check(tag);
   endtask

   task automatic finish_up();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures",
                  n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      finish_up();
   end

   initial begin
      logic [63:0] pat;
      logic [31:0] w;
      pat = 64'hF0E1_D2C3_B4A5_9687;

      // R12: reset state
      repeat (3) @(posedge clk);
      #(CLK_PERIOD/4);
      e_valid = 0; e_dst = 0; e_res = 0;
      check("R12 reset");
      @(negedge clk); rst = 1'b0;

      // R5 / R1: logical right in both widths, distinct amounts
      run(mk(1, 5'd2, 2'b01, 5'd3, 5'd7),  pat, 64'd4,  "R5 lsr64");
      run(mk(1, 5'd2, 2'b01, 5'd3, 5'd8),  pat, 64'd63, "R5 lsr64 max");
      run(mk(0, 5'd2, 2'b01, 5'd3, 5'd9),  pat, 64'd8,  "R1 lsr32");
      // R9: upper half of the first operand ignored in narrow mode
      run(mk(0, 5'd1, 2'b01, 5'd1, 5'd1),  64'hFFFF_FFFF_0000_0010, 64'd1, "R9 upper");
      // R4: amounts past the width wrap
      run(mk(0, 5'd4, 2'b01, 5'd5, 5'd6),  pat, 64'd33, "R4 mod32");
      run(mk(1, 5'd4, 2'b01, 5'd5, 5'd6),  pat, 64'hABCD_0000_0000_0045, "R4 mod64");
      // R10: zero after reduction
      run(mk(1, 5'd0, 2'b10, 5'd0, 5'd30), pat, 64'd64, "R10 zero64");
      run(mk(0, 5'd0, 2'b11, 5'd0, 5'd31), pat, 64'd32, "R10 zero32");
      // R6 / R7 / R8 in both widths
      run(mk(1, 5'd6, 2'b00, 5'd7, 5'd10), pat, 64'd12, "R6 lsl64");
      run(mk(0, 5'd6, 2'b00, 5'd7, 5'd11), pat, 64'd20, "R6 lsl32");
      run(mk(1, 5'd6, 2'b10, 5'd7, 5'd12), pat, 64'd17, "R7 asr64");
      run(mk(0, 5'd6, 2'b10, 5'd7, 5'd13), 64'h0000_0000_8000_0001, 64'd31, "R7 asr32");
      run(mk(0, 5'd6, 2'b10, 5'd7, 5'd14), 64'h8000_0000_7000_0000, 64'd4,  "R7 asr32 pos");
      run(mk(1, 5'd6, 2'b11, 5'd7, 5'd15), pat, 64'd37, "R8 ror64");
      run(mk(0, 5'd6, 2'b11, 5'd7, 5'd16), pat, 64'd5,  "R8 ror32");

      // R3: source indices are combinational
      @(negedge clk);
      instr_i = mk(1, 5'd19, 2'b01, 5'd27, 5'd4);
      #1;
      n_checks++;
      if (src_n_o !== 5'd27 || src_m_o !== 5'd19) begin
         n_fail++;
         $display("FAIL R3 src: got n=%0d m=%0d exp n=27 m=19", src_n_o, src_m_o);
      end
      // R11: registered outputs hold until the edge
      check("R11 hold");
      @(posedge clk);
      model(instr_i, opa_i, opb_i);
      #(CLK_PERIOD/4);
      check("R3 dst");

      // R2: corrupt each fixed bit in turn
      for (int k = 12; k < 31; k++) begin
         if (k < 16 || k > 20) begin
            w = mk(1, 5'd3, 2'b01, 5'd3, 5'd3);
            w[k] = ~w[k];
            run(w, pat, 64'd1, "R2 reject");
         end
      end

      // R12: reset in the middle of traffic
      @(negedge clk);
      instr_i = mk(1, 5'd1, 2'b00, 5'd1, 5'd22); rst = 1'b1;
      @(posedge clk);
      #(CLK_PERIOD/4);
      e_valid = 0; e_dst = 0; e_res = 0;
      check("R12 mid");
      @(negedge clk); rst = 1'b0;

      // mixed traffic, every amount bit pattern
      for (int n = 0; n < 400; n++) begin
         logic [31:0] ins;
         logic [63:0] a, b;
         ins = $urandom;
         if (n % 4 != 0) begin
            ins[30:21] = 10'b0011010110;
            ins[15:12] = 4'b0010;
         end
         a = {$urandom, $urandom};
         b = {$urandom, $urandom};
         case (ins[11:10])
            2'b00: run(ins, a, b, "R6 mix");
            2'b01: run(ins, a, b, "R5 mix");
            2'b10: run(ins, a, b, "R7 mix");
            default: run(ins, a, b, "R8 mix");
         endcase
      end

      finish_up();
   end

endmodule